// File: doc/BRIEF.md
# SPI Master Controller with Byte FIFOs

This block is a register-programmed SPI master. Software reaches it through a simple 32-bit register bus with word indices. It loads bytes into a transmit FIFO and picks the clock polarity, the sampling phase and the bit order. It then clears a hold bit so that clocking may begin. The shift engine drains the transmit FIFO one byte at a time. Each byte goes out on MOSI over eight SCLK periods, and the byte captured from MISO (or from MOSI in loopback) is pushed into a receive FIFO.

Slave-select lines come straight from an active-low register. Software can poll FIFO flags and fill counts, flush either FIFO on its own, and return the whole block to its reset state by writing a key value to a reset register. SCLK runs at the system clock divided by the even parameter `DIV`.

Bus reads are combinational: `bus_rdata` reflects `bus_addr` in the same cycle. A read strobe on the receive-data index pops one byte at the next clock edge. Writes take effect at the clock edge on which `bus_wr` is sampled high.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control word (index 24) reads 0x180, the status word (index 25) reads 0x25, both occupancy words (indices 29, 30) read 0, the select word (index 28) reads all ones, and SCLK is low.
- R2: While the hold bit (control bit 8) is 1, no SCLK edge occurs and queued transmit bytes stay in the FIFO. Writing it to 0 starts draining the FIFO.
- R3: With control bit 1 (enable) or control bit 2 (master) at 0, SCLK stays at the idle level given by control bit 3 and no byte leaves the transmit FIFO.
- R4: Control bit 3 sets the SCLK idle level. Control bit 4 = 0 samples on the first edge of each bit and 1 samples on the second. Control bit 9 = 1 sends bit 0 first, otherwise bit 7 goes first. The bytes seen on MOSI match the written bytes in order.
- R5: Every transmitted byte pushes exactly one received byte, taken from MISO, into the receive FIFO, in transfer order. It is read back at index 27.
- R6: With control bit 0 set, the receive shifter takes its input from MOSI instead of MISO, so each received byte equals the byte sent.
- R7: The select outputs `ss_n` equal the low NSS bits last written to index 28. Readback of index 28 returns those bits with all unused upper bits as 1.
- R8: Writing exactly 0x0000000A to index 16 restores every reset value (control, select, both FIFOs emptied). Any other value written there changes nothing.
- R9: Status bit 0 is receive-empty, bit 1 receive-full, bit 2 transmit-empty (FIFO empty and shifter idle), bit 3 transmit-full, bit 5 reads 1. Occupancy reads return count minus one (0 when empty). A write to a full transmit FIFO is dropped, and a byte received while the receive FIFO is full is discarded.
- R10: Reading index 27 while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R11: Writing control bit 5 or bit 6 as 1 empties the transmit or the receive FIFO respectively. Both bits read back as 0.
- R12: Consecutive SCLK edges within a byte are DIV/2 system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at index 27) |
| bus_addr | input | 5 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
A register write is visible on `bus_rdata` from the cycle after its strobe edge. The first SCLK edge follows a start-permitting write by one load cycle plus DIV/2 cycles. A byte is complete 16·DIV/2 cycles after its load, and both transmit-empty and the received byte appear at the edge that ends the last half period. The bench never assumes an exact byte latency. It polls status bit 2 and reads the receive FIFO only after that bit rises. It drives inputs on the falling clock edge and samples outputs just after that edge. A falling-edge monitor counts SCLK edges, checks their spacing, reassembles MOSI bytes and plays a slave on MISO using the mode the bench wrote.

// File: rtl/spim_pkg.sv
package spim_pkg;
   // register word indices (software decodes these)
   localparam int unsigned IX_SRST  = 16;
   localparam int unsigned IX_CTRL  = 24;
   localparam int unsigned IX_STAT  = 25;
   localparam int unsigned IX_TXD   = 26;
   localparam int unsigned IX_RXD   = 27;
   localparam int unsigned IX_SSEL  = 28;
   localparam int unsigned IX_TXOCC = 29;
   localparam int unsigned IX_RXOCC = 30;

   localparam logic [31:0] SRST_KEY = 32'h0000_000A;

   // control bit positions
   localparam int unsigned CB_LOOP  = 0;
   localparam int unsigned CB_EN    = 1;
   localparam int unsigned CB_MSTR  = 2;
   localparam int unsigned CB_CPOL  = 3;
   localparam int unsigned CB_CPHA  = 4;
   localparam int unsigned CB_TXFL  = 5;
   localparam int unsigned CB_RXFL  = 6;
   localparam int unsigned CB_MANSS = 7;
   localparam int unsigned CB_HOLD  = 8;
   localparam int unsigned CB_LSB   = 9;
   localparam int unsigned CTRL_W   = 10;

   localparam logic [CTRL_W-1:0] CTRL_RST = 10'h180;

   typedef struct packed {
      logic loop;
      logic cpol;
      logic cpha;
      logic lsb;
   } spim_mode_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int unsigned DIV = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       clr,
   input  logic       en,
   input  spim_mode_t mode,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       busy,
   output logic       sclk,
   output logic       mosi,
   output logic       rx_push,
   output logic [7:0] rx_byte
);
   localparam int unsigned HALF = DIV / 2;
   localparam int unsigned HW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic [7:0]    tsh, rsh, rnext;
   logic [3:0]    edg;
   logic          ph, tick, samp, adv, rin;
   logic [HW-1:0] hcnt;

   if (HALF == 1) begin : g_tick_every
      assign tick = busy;
      always_ff @(posedge clk) hcnt <= '0;
   end else begin : g_tick_count
      assign tick = busy && (hcnt == HW'(HALF - 1));
      always_ff @(posedge clk) begin
         if (rst || clr || !busy || tick) hcnt <= '0;
         else                             hcnt <= hcnt + 1'b1;
      end
   end

   // first-edge sampling: even edges sample, odd edges shift
   assign samp  = mode.cpha ? edg[0] : ~edg[0];
   assign adv   = mode.cpha ? (~edg[0] && edg != 4'd0) : edg[0];
   assign mosi  = mode.lsb ? tsh[0] : tsh[7];
   assign rin   = mode.loop ? mosi : miso;
   assign rnext = mode.lsb ? {rin, rsh[7:1]} : {rsh[6:0], rin};
   assign sclk  = mode.cpol ^ ph;

   assign rx_push = tick && (edg == 4'd15);
   assign rx_byte = samp ? rnext : rsh;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         busy <= 1'b0;
         ph   <= 1'b0;
         edg  <= '0;
         tsh  <= 8'hFF;
         rsh  <= '0;
      end else if (!en) begin
         busy <= 1'b0;
         ph   <= 1'b0;
         edg  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         ph   <= 1'b0;
         edg  <= '0;
         tsh  <= tx_byte;
      end else if (tick) begin
         ph  <= ~ph;
         edg <= edg + 1'b1;
         if (samp) rsh <= rnext;
         if (adv)  tsh <= mode.lsb ? {1'b1, tsh[7:1]} : {tsh[6:0], 1'b1};
         if (edg == 4'd15) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DIV   = 4,
   parameter int unsigned NSS   = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bus_wr,
   input  logic           bus_rd,
   input  logic [4:0]     bus_addr,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   output logic           sclk,
   output logic           mosi,
   input  logic           miso,
   output logic [NSS-1:0] ss_n
);
   localparam int unsigned CW = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1;

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("spim_ctrl: DIV must be even and at least 2");
   end
   if (NSS < 1 || NSS > 32) begin : g_bad_nss
      $error("spim_ctrl: NSS must lie in 1..32");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [NSS-1:0]    ss_q;
   logic              wr_ctrl, srst, tx_clr, rx_clr;
   logic              eng_busy, eng_en, can_start, rx_push;
   logic [7:0]        tx_dout, rx_dout, rx_byte;
   logic [CW-1:0]     tx_count, rx_count;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [31:0]       ss_rd, stat_rd;
   spim_mode_t        mode;

   assign wr_ctrl = bus_wr && (bus_addr == 5'(IX_CTRL));
   assign srst    = bus_wr && (bus_addr == 5'(IX_SRST)) && (bus_wdata == SRST_KEY);
   assign tx_clr  = srst || (wr_ctrl && bus_wdata[CB_TXFL]);
   assign rx_clr  = srst || (wr_ctrl && bus_wdata[CB_RXFL]);

   always_ff @(posedge clk) begin
      if (rst || srst) begin
         ctrl_q <= CTRL_RST;
         ss_q   <= '1;
      end else begin
         if (wr_ctrl) begin
            ctrl_q          <= bus_wdata[CTRL_W-1:0];
            ctrl_q[CB_TXFL] <= 1'b0;
            ctrl_q[CB_RXFL] <= 1'b0;
         end
         if (bus_wr && bus_addr == 5'(IX_SSEL)) ss_q <= bus_wdata[NSS-1:0];
      end
   end

   assign mode.loop = ctrl_q[CB_LOOP];
   assign mode.cpol = ctrl_q[CB_CPOL];
   assign mode.cpha = ctrl_q[CB_CPHA];
   assign mode.lsb  = ctrl_q[CB_LSB];
   assign eng_en    = ctrl_q[CB_EN] && ctrl_q[CB_MSTR];
   assign can_start = eng_en && !ctrl_q[CB_HOLD] && !tx_empty && !eng_busy;
   assign ss_n      = ss_q;

   spim_fifo #(.W(8), .DEPTH(DEPTH)) u_txf (
      .clk(clk), .rst(rst), .clr(tx_clr),
      .push(bus_wr && bus_addr == 5'(IX_TXD)), .din(bus_wdata[7:0]),
      .pop(can_start), .dout(tx_dout), .count(tx_count),
      .empty(tx_empty), .full(tx_full)
   );

   spim_fifo #(.W(8), .DEPTH(DEPTH)) u_rxf (
      .clk(clk), .rst(rst), .clr(rx_clr),
      .push(rx_push), .din(rx_byte),
      .pop(bus_rd && bus_addr == 5'(IX_RXD)), .dout(rx_dout), .count(rx_count),
      .empty(rx_empty), .full(rx_full)
   );

   spim_engine #(.DIV(DIV)) u_eng (
      .clk(clk), .rst(rst), .clr(srst), .en(eng_en), .mode(mode),
      .start(can_start), .tx_byte(tx_dout), .miso(miso),
      .busy(eng_busy), .sclk(sclk), .mosi(mosi),
      .rx_push(rx_push), .rx_byte(rx_byte)
   );

   if (NSS < 32) begin : g_ss_pad
      assign ss_rd = {{(32 - NSS){1'b1}}, ss_q};
   end else begin : g_ss_full
      assign ss_rd = ss_q;
   end

   assign stat_rd = {26'd0, 1'b1, 1'b0, tx_full, tx_empty && !eng_busy, rx_full, rx_empty};

   function automatic logic [31:0] occ(input logic [CW-1:0] c);
      return (c == '0) ? 32'd0 : 32'(c - 1'b1);
   endfunction

   always_comb begin
      case (bus_addr)
         5'(IX_CTRL):  bus_rdata = {{(32 - CTRL_W){1'b0}}, ctrl_q};
         5'(IX_STAT):  bus_rdata = stat_rd;
         5'(IX_RXD):   bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
         5'(IX_SSEL):  bus_rdata = ss_rd;
         5'(IX_TXOCC): bus_rdata = occ(tx_count);
         5'(IX_RXOCC): bus_rdata = occ(rx_count);
         default:      bus_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CW    = 5
) (
   input logic          clk,
   input logic          rst,
   input logic          busy,
   input logic          sclk,
   input logic [9:0]    ctrl,
   input logic [CW-1:0] tx_count,
   input logic [CW-1:0] rx_count,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [4:0]    bus_addr,
   input logic [31:0]   bus_wdata,
   input logic [31:0]   bus_rdata
);
   p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (sclk == ctrl[3]));

   p_hold_blocks_r2: assert property (@(posedge clk) disable iff (rst)
      (ctrl[8] && !busy) |=> !busy);

   p_start_has_data_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> ($past(tx_count) != '0));

   p_rx_bound_r9: assert property (@(posedge clk) disable iff (rst)
      rx_count <= CW'(DEPTH));

   p_key_reset_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 5'd16 && bus_wdata == 32'h0A) |=>
      (ctrl == 10'h180 && tx_count == '0 && rx_count == '0 && !busy));

   p_empty_read_r10: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == 5'd27 && rx_count == '0) |-> (bus_rdata == 32'd0));
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst(rst), .busy(eng_busy), .sclk(sclk), .ctrl(ctrl_q),
   .tx_count(tx_count), .rx_count(rx_count), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
   localparam int DEPTH = 16;
   localparam int DIV   = 4;
   localparam int HALF  = DIV / 2;
   localparam int NSS   = 4;

   logic        clk = 1'b0, rst = 1'b1;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        sclk, mosi;
   logic        miso = 1'b1;
   logic [NSS-1:0] ss_n;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   spim_ctrl #(.DEPTH(DEPTH), .DIV(DIV), .NSS(NSS)) uut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
      .miso(miso), .ss_n(ss_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- bench mode state and monitor ----------------
   bit m_cpol, m_cpha, m_lsb, m_loop;
   bit mon_en = 0;
   logic [7:0] txq[$], slq[$], rxq[$];
   logic [7:0] mbyte, sb;
   int e = 0, sidx = 0, edges = 0, cyc = 0, last_edge = 0;
   logic prev_sclk = 1'b0;

   function automatic logic sbit(input logic [7:0] b, input int i, input bit lsb);
      return lsb ? b[i] : b[7 - i];
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (mon_en && sclk !== prev_sclk) begin
         edges++;
         if (e == 1) chk("R12 half period", 32'(cyc - last_edge), 32'(HALF));
         last_edge = cyc;
         if (m_cpha ? (e % 2 == 1) : (e % 2 == 0))
            mbyte = m_lsb ? {mosi, mbyte[7:1]} : {mbyte[6:0], mosi};
         if (m_cpha ? (e % 2 == 0 && e != 0) : (e % 2 == 1)) begin
            sidx++;
            if (sidx < 8) miso = sbit(sb, sidx, m_lsb);
         end
         e++;
         if (e == 16) begin
            e = 0;
            if (txq.size() != 0) chk("R4 mosi byte", {24'd0, mbyte}, {24'd0, txq.pop_front()});
            else chk("R4 unexpected byte", 32'd1, 32'd0);
            sb   = (slq.size() != 0) ? slq.pop_front() : 8'hFF;
            sidx = 0;
            miso = sbit(sb, 0, m_lsb);
         end
      end
      prev_sclk = sclk;
   end

   // ---------------- bus tasks (called at a falling edge) ----------------
   task automatic wr(input int a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = 5'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input bit hold, en, mstr);
      return 32'((int'(m_lsb) << 9) | (int'(hold) << 8) | (int'(m_cpha) << 4) |
                 (int'(m_cpol) << 3) | (int'(mstr) << 2) | (int'(en) << 1) | int'(m_loop));
   endfunction

   task automatic set_mode(input bit lp, cp, ch, ls);
      m_loop = lp; m_cpol = cp; m_cpha = ch; m_lsb = ls;
      wr(24, ctrl_word(1'b1, 1'b1, 1'b1));
   endtask

   task automatic push_byte(input logic [7:0] b, input logic [7:0] s);
      wr(26, {24'd0, b});
      txq.push_back(b);
      slq.push_back(s);
      rxq.push_back(m_loop ? b : s);
   endtask

   task automatic go(input string tag);
      logic [31:0] st;
      sb   = (slq.size() != 0) ? slq.pop_front() : 8'hFF;
      sidx = 0;
      miso = sbit(sb, 0, m_lsb);
      e = 0; edges = 0;
      repeat (6) @(negedge clk);
      chk({tag, " R2 no edge while held"}, 32'(edges), 32'd0);
      mon_en = 1;
      wr(24, ctrl_word(1'b0, 1'b1, 1'b1));
      do rd(25, st); while (st[2] !== 1'b1);
      mon_en = 0;
      wr(24, ctrl_word(1'b1, 1'b1, 1'b1));
      chk({tag, " R4 idle level"}, {31'd0, sclk}, {31'd0, m_cpol});
      chk({tag, " R4 all bytes seen"}, 32'(txq.size()), 32'd0);
   endtask

   task automatic drain(input string tag, input int n);
      logic [31:0] v;
      for (int i = 0; i < n; i++) begin
         rd(27, v);
         chk(tag, v, {24'd0, rxq.pop_front()});
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      rd(24, v); chk("R1 control", v, 32'h180);
      rd(25, v); chk("R1 status", v, 32'h25);
      rd(28, v); chk("R1 select readback", v, 32'hFFFF_FFFF);
      rd(29, v); chk("R1 tx occupancy", v, 0);
      rd(30, v); chk("R1 rx occupancy", v, 0);
      chk("R1 sclk low", {31'd0, sclk}, 0);

      // R7 select register
      wr(28, 32'hFFFF_FFFD);
      chk("R7 ss_n", {28'd0, ss_n}, 32'hD);
      rd(28, v); chk("R7 readback", v, 32'hFFFF_FFFD);

      // R10 empty read
      rd(27, v); chk("R10 empty read", v, 0);
      rd(25, v); chk("R10 still empty", {31'd0, v[0]}, 1);

      // R3 enable / master gating with idle level 1
      m_loop = 1; m_cpol = 1; m_cpha = 0; m_lsb = 0;
      wr(24, ctrl_word(1'b0, 1'b0, 1'b1));
      wr(26, 32'hA5);
      repeat (20) @(negedge clk);
      chk("R3 enable low sclk idle", {31'd0, sclk}, 1);
      rd(25, v); chk("R3 enable low tx kept", {31'd0, v[2]}, 0);
      wr(24, ctrl_word(1'b0, 1'b1, 1'b0));
      repeat (20) @(negedge clk);
      chk("R3 master low sclk idle", {31'd0, sclk}, 1);
      rd(25, v); chk("R3 master low tx kept", {31'd0, v[2]}, 0);

      // R11 transmit flush
      wr(24, ctrl_word(1'b1, 1'b1, 1'b1) | 32'h20);
      rd(25, v); chk("R11 tx flushed", {31'd0, v[2]}, 1);
      rd(24, v); chk("R11 flush bit reads 0", {31'd0, v[5]}, 0);

      // R2 hold, R9 full transmit FIFO and dropped write
      set_mode(1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) push_byte(8'(i * 7 + 3), 8'h00);
      wr(26, 32'hEE);
      rd(29, v); chk("R9 tx occupancy full", v, DEPTH - 1);
      rd(25, v); chk("R9 tx full flag", {31'd0, v[3]}, 1);
      chk("R2 sclk idle while held", {31'd0, sclk}, 0);
      go("full");
      rd(30, v); chk("R9 rx occupancy full", v, DEPTH - 1);
      rd(25, v); chk("R9 rx full flag", {31'd0, v[1]}, 1);
      // a byte arriving at a full receive FIFO is discarded
      push_byte(8'h5A, 8'h00);
      void'(rxq.pop_back());
      go("overrun");
      rd(30, v); chk("R9 rx occupancy after drop", v, DEPTH - 1);
      drain("R6 loopback full rx", DEPTH);
      rd(25, v); chk("R9 rx empty after drain", {31'd0, v[0]}, 1);

      // R5 plain MISO capture in all four modes
      for (int md = 0; md < 4; md++) begin
         set_mode(1'b0, md[1], md[0], md[1] ^ md[0]);
         for (int i = 0; i < 3; i++) push_byte(8'($urandom), 8'($urandom));
         go("R5 mode");
         drain("R5 miso byte", 3);
      end

      // random mixture
      for (int it = 0; it < 12; it++) begin
         int n;
         bit lp, cp, ch, ls;
         n = int'($urandom_range(1, 5));
         lp = 1'($urandom); cp = 1'($urandom); ch = 1'($urandom); ls = 1'($urandom);
         set_mode(lp, cp, ch, ls);
         for (int i = 0; i < n; i++) push_byte(8'($urandom), 8'($urandom));
         go("rand");
         drain(lp ? "R6 loopback byte" : "R5 miso byte", n);
      end

      // R11 receive flush
      set_mode(1'b1, 1'b0, 1'b1, 1'b0);
      push_byte(8'h11, 0); push_byte(8'h22, 0);
      go("rxflush");
      rxq.delete();
      wr(24, ctrl_word(1'b1, 1'b1, 1'b1) | 32'h40);
      rd(30, v); chk("R11 rx occupancy after flush", v, 0);
      rd(25, v); chk("R11 rx empty after flush", {31'd0, v[0]}, 1);

      // R8 soft reset key
      wr(28, 32'h0000_0006);
      wr(26, 32'h77);
      wr(16, 32'h0000_0005);
      rd(24, v); chk("R8 wrong key ignored ctrl", v, ctrl_word(1'b1, 1'b1, 1'b1));
      rd(25, v); chk("R8 wrong key keeps tx", {31'd0, v[2]}, 0);
      chk("R8 wrong key keeps select", {28'd0, ss_n}, 32'h6);
      wr(16, 32'h0000_000A);
      rd(24, v); chk("R8 key restores control", v, 32'h180);
      rd(25, v); chk("R8 key restores status", v, 32'h25);
      chk("R8 key restores select", {28'd0, ss_n}, 32'hF);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R2 watchdog: actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule